// File: doc/BRIEF.md
# Effective Address Mode Decoder

This block turns the 6-bit mode/register field of an instruction into an addressing-mode descriptor: a set of mode flags, a register number, and whatever displacement, absolute address, index word or immediate operand the mode carries in extension words. A front end presents the field and the operand size with a one-cycle `start` pulse. Extension words then arrive one at a time over a valid/ready stream, and the block pulls exactly as many as the mode needs.

When the descriptor is complete, the block raises `done` for one cycle. At that point it also reports a status code and the number of extension bytes it consumed, so the front end can advance its fetch pointer. Encodings without a defined meaning end at once with an illegal-mode status. A fetch fault flagged on the stream ends the decode with a separate fault status.

For indexed forms, the single extension word is passed on unchanged for a separate index decoder to interpret. Address arithmetic and memory access are left to later stages. All descriptor outputs hold their values until the next accepted `start`.

Top module: `eaModeDecoder`

## Requirements
- R1: Field bits 5:3 equal to 0 or 1 (register direct) produce flags 0x01 (bit 0 = direct) and consume no words, so advance is 0. The register number is the low 3 bits for 0 and 8 plus the low 3 bits for 1. `done` rises in the cycle after `start`.
- R2: Modes 2, 3 and 4 (register indirect, postincrement, predecrement) consume no words. They give register number 8 plus the low 3 bits and flags 0x00, 0x02 (bit 1) and 0x04 (bit 2) respectively.
- R3: Mode 5 takes one word and sign-extends it onto `dispOut`. It gives flags 0x08 (bit 3 = offset), register number 8 plus the low 3 bits, and advance 2.
- R4: Mode 6, and mode 7 with low bits 3, take one word and pass it unchanged on `idxWord`, with advance 2. The flags are 0x10 (bit 4 = indexed) for mode 6, with register 8 plus the low 3 bits. For mode 7 with low bits 3 they are 0x50 (bit 6 = PC-relative), with register 3.
- R5: Mode 7 with low bits 0 takes one word and sign-extends it onto `dispOut` as an absolute address. It gives flags 0x20 (bit 5 = absolute), register 0 and advance 2.
- R6: Mode 7 with low bits 1 takes two words, the first being the upper half of `dispOut`. It gives flags 0x20, register 1 and advance 4.
- R7: Mode 7 with low bits 2 takes one word and sign-extends it onto `dispOut`. It gives flags 0x48 (PC-relative plus offset), register 2 and advance 2.
- R8: Mode 7 with low bits 4 is immediate, with flags 0x80 (bit 7). With `opSize` 1 it takes one word and sign-extends its low 8 bits into `immOut[31:0]`. With `opSize` 2 it takes one word and sign-extends all 16 bits. In both cases advance is 2.
- R9: An immediate with `opSize` 4, 8 or 12 takes 2, 4 or 6 words (advance 4, 8, 12). Each pair of words, first word upper, fills the next 32-bit slot of `immOut`, starting at bits 31:0. Slots that are not filled read zero.
- R10: Mode 7 with low bits 5, 6 or 7, and an immediate whose `opSize` is not 1, 2, 4, 8 or 12, end with status 1 (illegal). `extReady` never rises, advance is 0, and flags and register number read 0.
- R11: A word presented with `extFault` high ends the decode with status 2 (fault). The faulting word is not counted, so advance reports only the words taken before it.
- R12: A word is taken only on a cycle where both `extValid` and `extReady` are high. A `start` pulse while busy is ignored. `done` lasts one cycle, status 0 means success, and the outputs hold their values while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding `modeReg`/`opSize` (ignored while busy) |
| modeReg | input | 6 | Mode (bits 5:3) and register (bits 2:0) field |
| opSize | input | 4 | Operand size in bytes, used by immediates |
| extValid | input | 1 | Extension word present |
| extData | input | 16 | Extension word |
| extFault | input | 1 | Fetch fault on the presented word |
| extReady | output | 1 | Block will take the presented word |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 illegal mode, 2 fetch fault |
| flags | output | 8 | Mode flags descriptor |
| regNum | output | 4 | Register number |
| dispOut | output | 32 | Offset or absolute address |
| immOut | output | 96 | Immediate operand, three 32-bit slots |
| idxWord | output | 16 | Index extension word for the index decoder |
| advance | output | 4 | Extension bytes consumed |

## Verification
Some properties are checked on every cycle: `extReady` is only high while busy, `done` is a single-cycle pulse, the advance count stays within 12 and holds while idle, and both illegal and register-direct completions report zero advance. Everything that depends on values can only be shown by the bench scenarios. That covers sign extension at the 8- and 16-bit boundaries, word order within pairs, which immediate slot each pair fills, the indexed word hand-off, fault accounting, stalled streams, and a `start` arriving mid-decode.

// File: rtl/eaPkg.sv
`timescale 1ns/1ps
package eaPkg;
  localparam int WORD_W    = 16;
  localparam int MAX_WORDS = 6;
  localparam int IDX_W     = $clog2(MAX_WORDS);
  localparam int ADV_W     = $clog2(2 * MAX_WORDS + 1);

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_ILLEGAL = 2'd1;
  localparam logic [1:0] ST_FAULT   = 2'd2;

  typedef enum logic [2:0] {
    K_NONE, K_DISP16, K_ABS32, K_IMM, K_IDX
  } eaKindE;

  typedef struct packed {
    logic             latchCmd;
    logic             illegal;
    logic             capWord;
    logic [IDX_W-1:0] wordIdx;
    logic             fault;
  } eaStrobesT;
endpackage

// File: rtl/eaModeDecode.sv
`timescale 1ns/1ps
module eaModeDecode
  import eaPkg::*;
(
  input  logic [5:0]       modeReg,
  input  logic [3:0]       opSize,
  output logic [7:0]       dFlags,
  output logic [3:0]       dReg,
  output logic [IDX_W:0]   dNeed,
  output eaKindE           dKind,
  output logic             dIllegal
);
  logic [2:0] modeF;
  logic [2:0] regF;
  assign modeF = modeReg[5:3];
  assign regF  = modeReg[2:0];

  always_comb begin
    dFlags   = 8'h00;
    dReg     = {1'b1, regF};
    dNeed    = '0;
    dKind    = K_NONE;
    dIllegal = 1'b0;
    case (modeF)
      3'd0: begin dFlags = 8'h01; dReg = {1'b0, regF}; end
      3'd1: dFlags = 8'h01;
      3'd2: dFlags = 8'h00;
      3'd3: dFlags = 8'h02;
      3'd4: dFlags = 8'h04;
      3'd5: begin dFlags = 8'h08; dNeed = 1; dKind = K_DISP16; end
      3'd6: begin dFlags = 8'h10; dNeed = 1; dKind = K_IDX; end
      default: begin
        dReg = {1'b0, regF};
        case (regF)
          3'd0: begin dFlags = 8'h20; dNeed = 1; dKind = K_DISP16; end
          3'd1: begin dFlags = 8'h20; dNeed = 2; dKind = K_ABS32; end
          3'd2: begin dFlags = 8'h48; dNeed = 1; dKind = K_DISP16; end
          3'd3: begin dFlags = 8'h50; dNeed = 1; dKind = K_IDX; end
          3'd4: begin
            dFlags = 8'h80;
            dKind  = K_IMM;
            case (opSize)
              4'd1, 4'd2: dNeed = 1;
              4'd4:       dNeed = 2;
              4'd8:       dNeed = 4;
              4'd12:      dNeed = 6;
              default:    dIllegal = 1'b1;
            endcase
          end
          default: dIllegal = 1'b1;
        endcase
      end
    endcase
    if (dIllegal) begin
      dFlags = 8'h00;
      dReg   = 4'd0;
      dNeed  = '0;
      dKind  = K_NONE;
    end
  end
endmodule

// File: rtl/eaCtrl.sv
`timescale 1ns/1ps
module eaCtrl
  import eaPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [IDX_W:0] dNeed,
  input  logic           dIllegal,
  input  logic           extValid,
  input  logic           extFault,
  output logic           extReady,
  output logic           busy,
  output logic           done,
  output eaStrobesT      strobes
);
  typedef enum logic {S_IDLE, S_FETCH} stateE;
  stateE          state;
  logic [IDX_W:0] needReg;
  logic [IDX_W:0] cnt;
  logic           takeWord;

  assign extReady = (state == S_FETCH);
  assign busy     = (state != S_IDLE);
  assign takeWord = extReady && extValid;

  always_comb begin
    strobes          = '0;
    strobes.latchCmd = (state == S_IDLE) && start;
    strobes.illegal  = dIllegal;
    strobes.capWord  = takeWord && !extFault;
    strobes.fault    = takeWord && extFault;
    strobes.wordIdx  = cnt[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      needReg <= '0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            needReg <= dNeed;
            cnt     <= '0;
            if (dIllegal || dNeed == '0) done  <= 1'b1;
            else                          state <= S_FETCH;
          end
        end
        default: begin
          if (takeWord) begin
            if (extFault) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
              if (cnt + 1'b1 == needReg) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eaDatapath.sv
`timescale 1ns/1ps
module eaDatapath
  import eaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  eaStrobesT         strobes,
  input  logic [7:0]        dFlags,
  input  logic [3:0]        dReg,
  input  eaKindE            dKind,
  input  logic [3:0]        opSize,
  input  logic [WORD_W-1:0] extData,
  output logic [1:0]        status,
  output logic [7:0]        flags,
  output logic [3:0]        regNum,
  output logic [31:0]       dispOut,
  output logic [95:0]       immOut,
  output logic [WORD_W-1:0] idxWord,
  output logic [ADV_W-1:0]  advance
);
  logic [WORD_W-1:0] wordBuf [MAX_WORDS];
  eaKindE            kindReg;
  logic [3:0]        sizeReg;

  for (genvar gi = 0; gi < MAX_WORDS; gi++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN || strobes.latchCmd) wordBuf[gi] <= '0;
      else if (strobes.capWord && strobes.wordIdx == IDX_W'(gi))
        wordBuf[gi] <= extData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status  <= ST_OK;
      flags   <= '0;
      regNum  <= '0;
      kindReg <= K_NONE;
      sizeReg <= '0;
      advance <= '0;
    end else if (strobes.latchCmd) begin
      status  <= strobes.illegal ? ST_ILLEGAL : ST_OK;
      flags   <= dFlags;
      regNum  <= dReg;
      kindReg <= dKind;
      sizeReg <= opSize;
      advance <= '0;
    end else if (strobes.capWord) begin
      advance <= advance + ADV_W'(2);
    end else if (strobes.fault) begin
      status <= ST_FAULT;
    end
  end

  always_comb begin
    dispOut = '0;
    immOut  = '0;
    idxWord = '0;
    case (kindReg)
      K_DISP16: dispOut = {{16{wordBuf[0][15]}}, wordBuf[0]};
      K_ABS32:  dispOut = {wordBuf[0], wordBuf[1]};
      K_IDX:    idxWord = wordBuf[0];
      K_IMM: begin
        if (sizeReg == 4'd1)
          immOut[31:0] = {{24{wordBuf[0][7]}}, wordBuf[0][7:0]};
        else if (sizeReg == 4'd2)
          immOut[31:0] = {{16{wordBuf[0][15]}}, wordBuf[0]};
        else
          immOut = {wordBuf[4], wordBuf[5], wordBuf[2], wordBuf[3],
                    wordBuf[0], wordBuf[1]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eaModeDecoder.sv
`timescale 1ns/1ps
module eaModeDecoder
  import eaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [5:0]  modeReg,
  input  logic [3:0]  opSize,
  input  logic        extValid,
  input  logic [15:0] extData,
  input  logic        extFault,
  output logic        extReady,
  output logic        busy,
  output logic        done,
  output logic [1:0]  status,
  output logic [7:0]  flags,
  output logic [3:0]  regNum,
  output logic [31:0] dispOut,
  output logic [95:0] immOut,
  output logic [15:0] idxWord,
  output logic [3:0]  advance
);
  logic [7:0]     dFlags;
  logic [3:0]     dReg;
  logic [IDX_W:0] dNeed;
  eaKindE         dKind;
  logic           dIllegal;
  eaStrobesT      strobes;

  eaModeDecode uDecode (
    .modeReg(modeReg), .opSize(opSize), .dFlags(dFlags), .dReg(dReg),
    .dNeed(dNeed), .dKind(dKind), .dIllegal(dIllegal)
  );

  eaCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .dNeed(dNeed),
    .dIllegal(dIllegal), .extValid(extValid), .extFault(extFault),
    .extReady(extReady), .busy(busy), .done(done), .strobes(strobes)
  );

  eaDatapath uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dFlags(dFlags),
    .dReg(dReg), .dKind(dKind), .opSize(opSize), .extData(extData),
    .status(status), .flags(flags), .regNum(regNum), .dispOut(dispOut),
    .immOut(immOut), .idxWord(idxWord), .advance(advance)
  );
endmodule

// File: rtl/eaModeDecoderChk.sv
`timescale 1ns/1ps
module eaModeDecoderChk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       extReady,
  input logic [1:0] status,
  input logic [7:0] flags,
  input logic [3:0] advance
);
  assert_ready_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    extReady |-> busy);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_adv_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(advance));
  assert_illegal_noadv_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'd1) |-> (advance == 4'd0 && flags == 8'h00));
  assert_direct_noadv_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'd0 && flags[0]) |-> advance == 4'd0);
  assert_adv_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    advance <= 4'd12);
endmodule

bind eaModeDecoder eaModeDecoderChk uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .extReady(extReady), .status(status), .flags(flags), .advance(advance)
);

// File: tb/tb_eaModeDecoder.sv
`timescale 1ns/1ps
module tb_eaModeDecoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  modeReg = '0;
  logic [3:0]  opSize = '0;
  logic        extValid = 1'b0;
  logic [15:0] extData = '0;
  logic        extFault = 1'b0;
  logic        extReady, busy, done;
  logic [1:0]  status;
  logic [7:0]  flags;
  logic [3:0]  regNum;
  logic [31:0] dispOut;
  logic [95:0] immOut;
  logic [15:0] idxWord;
  logic [3:0]  advance;

  eaModeDecoder dut (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    logic [7:0]  fl;
    logic [3:0]  rg;
    logic [1:0]  st;
    logic [3:0]  adv;
    logic [31:0] disp;
    logic [95:0] imm;
    logic [15:0] idx;
    string       tag;
  } expT;

  expT expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic expT mk(input logic [7:0] fl, input logic [3:0] rg,
      input logic [1:0] st, input logic [3:0] adv, input logic [31:0] disp,
      input logic [95:0] imm, input logic [15:0] idx, input string tag);
    expT e;
    e.fl = fl; e.rg = rg; e.st = st; e.adv = adv;
    e.disp = disp; e.imm = imm; e.idx = idx; e.tag = tag;
    return e;
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard on each completion pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        chk(0, "R12", "unexpected done", 96'd1, 96'd0);
      end else begin
        expT e;
        e = expQ.pop_front();
        chk(status == e.st, e.tag, "status", status, e.st);
        chk(advance == e.adv, e.tag, "advance", advance, e.adv);
        if (e.st == 2'd0) begin
          chk(flags == e.fl, e.tag, "flags", flags, e.fl);
          chk(regNum == e.rg, e.tag, "regNum", regNum, e.rg);
          chk(dispOut == e.disp, e.tag, "dispOut", dispOut, e.disp);
          chk(immOut == e.imm, e.tag, "immOut", immOut, e.imm);
          chk(idxWord == e.idx, e.tag, "idxWord", idxWord, e.idx);
        end
      end
    end
  end

  // Driver: pushes the expected item, then plays the command and its words
  task automatic runCase(input logic [5:0] mr, input logic [3:0] sz,
      input int nw, input logic [95:0] wv, input int faultAt,
      input bit busyPoke, input expT e);
    expQ.push_back(e);
    @(negedge clk);
    modeReg = mr; opSize = sz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (nw == 0) begin
      chk(!extReady, e.tag, "extReady after no-word start", extReady, 0);
    end
    for (int i = 0; i < nw; i++) begin
      if (busyPoke && i == 0) begin
        modeReg = 6'o00; start = 1'b1;
        @(negedge clk);
        start = 1'b0; modeReg = mr;
      end
      if (i % 2 == 1) begin
        extValid = 1'b0;
        extData  = 16'hDEAD;
        @(negedge clk);
      end
      extValid = 1'b1;
      extData  = wv[16*i +: 16];
      extFault = (i == faultAt);
      while (!extReady) @(negedge clk);
      @(negedge clk);
      extValid = 1'b0;
      extFault = 1'b0;
      if (i == faultAt) break;
    end
    for (int k = 0; k < 20 && expQ.size() != 0; k++) @(negedge clk);
    chk(expQ.size() == 0, e.tag, "completion seen", expQ.size(), 0);
    expQ.delete();
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !extReady, "R12", "idle after reset", {busy, done, extReady}, 0);
    chk(advance == 0 && status == 0, "R12", "reset advance/status", {advance, status}, 0);

    // R1 register direct
    runCase(6'o05, 4'd4, 0, '0, -1, 0, mk(8'h01, 4'd5,  0, 0, 0, 0, 0, "R1"));
    runCase(6'o13, 4'd4, 0, '0, -1, 0, mk(8'h01, 4'd11, 0, 0, 0, 0, 0, "R1"));
    // R2 indirect forms
    runCase(6'o27, 4'd4, 0, '0, -1, 0, mk(8'h00, 4'd15, 0, 0, 0, 0, 0, "R2"));
    runCase(6'o32, 4'd4, 0, '0, -1, 0, mk(8'h02, 4'd10, 0, 0, 0, 0, 0, "R2"));
    runCase(6'o40, 4'd4, 0, '0, -1, 0, mk(8'h04, 4'd8,  0, 0, 0, 0, 0, "R2"));
    // R3 offset, with a start poked mid-decode (R12)
    runCase(6'o51, 4'd4, 1, 96'h8001, -1, 1,
            mk(8'h08, 4'd9, 0, 2, 32'hFFFF8001, 0, 0, "R3"));
    // R4 indexed forms
    runCase(6'o64, 4'd4, 1, 96'hA5C3, -1, 0,
            mk(8'h10, 4'd12, 0, 2, 0, 0, 16'hA5C3, "R4"));
    runCase(6'o73, 4'd4, 1, 96'h0123, -1, 0,
            mk(8'h50, 4'd3, 0, 2, 0, 0, 16'h0123, "R4"));
    // R5 absolute word
    runCase(6'o70, 4'd4, 1, 96'h7FFE, -1, 0,
            mk(8'h20, 4'd0, 0, 2, 32'h00007FFE, 0, 0, "R5"));
    // R6 absolute long, high word first, stalled second word
    runCase(6'o71, 4'd4, 2, {16'hABCD, 16'h1234}, -1, 0,
            mk(8'h20, 4'd1, 0, 4, 32'h1234ABCD, 0, 0, "R6"));
    // R7 PC-relative offset
    runCase(6'o72, 4'd4, 1, 96'hFFF0, -1, 0,
            mk(8'h48, 4'd2, 0, 2, 32'hFFFFFFF0, 0, 0, "R7"));
    // R8 byte and word immediates
    runCase(6'o74, 4'd1, 1, 96'h1280, -1, 0,
            mk(8'h80, 4'd4, 0, 2, 0, 96'hFFFFFF80, 0, "R8"));
    runCase(6'o74, 4'd1, 1, 96'hFF7F, -1, 0,
            mk(8'h80, 4'd4, 0, 2, 0, 96'h0000007F, 0, "R8"));
    runCase(6'o74, 4'd2, 1, 96'h7F00, -1, 0,
            mk(8'h80, 4'd4, 0, 2, 0, 96'h00007F00, 0, "R8"));
    // R9 long, 8- and 12-byte immediates
    runCase(6'o74, 4'd4, 2, {16'h0001, 16'hCAFE}, -1, 0,
            mk(8'h80, 4'd4, 0, 4, 0, 96'hCAFE0001, 0, "R9"));
    runCase(6'o74, 4'd8, 4, {16'h4444, 16'h3333, 16'h2222, 16'h1111}, -1, 0,
            mk(8'h80, 4'd4, 0, 8, 0, {32'h0, 32'h33334444, 32'h11112222}, 0, "R9"));
    runCase(6'o74, 4'd12, 6,
            {16'h6666, 16'h5555, 16'h4444, 16'h3333, 16'h2222, 16'h1111}, -1, 0,
            mk(8'h80, 4'd4, 0, 12, 0, {32'h55556666, 32'h33334444, 32'h11112222}, 0, "R9"));
    // R10 illegal encodings
    runCase(6'o75, 4'd4, 0, '0, -1, 0, mk(0, 0, 1, 0, 0, 0, 0, "R10"));
    runCase(6'o77, 4'd4, 0, '0, -1, 0, mk(0, 0, 1, 0, 0, 0, 0, "R10"));
    runCase(6'o74, 4'd3, 0, '0, -1, 0, mk(0, 0, 1, 0, 0, 0, 0, "R10"));
    chk(flags == 0 && regNum == 0, "R10", "illegal descriptor", {flags, regNum}, 0);
    // R11 fetch fault on second word of absolute long
    runCase(6'o71, 4'd4, 2, {16'hABCD, 16'h1234}, 1, 0,
            mk(0, 0, 2, 2, 0, 0, 0, "R11"));
    // R11 fault on first word of offset
    runCase(6'o50, 4'd4, 1, 96'h0004, 0, 0, mk(0, 0, 2, 0, 0, 0, 0, "R11"));
    // R12 outputs hold while idle
    repeat (4) @(negedge clk);
    chk(status == 2 && advance == 0 && !busy, "R12", "idle hold", {status, advance, busy}, {2'd2, 4'd0, 1'b0});
    finishRun();
  end
endmodule